// File: doc/BRIEF.md
# MDIO Management Controller

This block lets a host processor run IEEE 802.3 clause-22 management transactions on external PHYs over the MDC/MDIO pair. The host sees six 32-bit word registers on a plain register bus with an address, a write strobe, write data and combinational read data. A write frame starts when the host writes the data-to-send register. A read frame starts on a 0-to-1 transition of the read-request bit. The controller serialises each frame MSB first. It drives MDC from a programmable divider and captures the PHY's reply. Two flags report progress: busy, and data-not-valid.

The frame engine is a state machine with five states. **IDLE** moves to **PREAMBLE** on a launch (*launch*). **PREAMBLE** sends 32 ones and moves to **HEADER** on the 32nd falling MDC edge (*pre_done*). **HEADER** sends start `01`, the opcode, the PHY address and the register number, 14 bits in all, and moves to **TURN** (*hdr_done*). **TURN** sends the 2-bit turnaround and moves to **DATA** (*ta_done*). **DATA** moves 16 bits and returns to **IDLE** on its last falling MDC edge (*frame_done*). A configuration write with the reset bit set sends any state back to **IDLE** (*abort*). MDC runs only while the engine is out of IDLE. MDC idles low.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The register word indices are 0 configuration, 1 command, 2 address, 3 write-data, 4 status and 5 indication. After reset every register reads 0 except configuration, which reads 7. MDC is low and the MDIO output enable is low.
- R2: In the address register, PHY address bits 12:8 and register-number bits 4:0 are writable and read back. All other bits read 0.
- R3: Writing index 3 while idle starts a write frame: 32 ones, then `01`, opcode `01`, PHY address, register number, turnaround `10` and the low 16 bits of the written value, all MSB first, with the output enable high throughout. Indication bit 0 (busy) reads 1 from the cycle after the write until the frame ends.
- R4: A read frame starts only when command bit 0 goes from 0 to 1. Writing 1 while that bit is already 1 starts nothing.
- R5: A read frame sends opcode `10` and holds the output enable low for the 2 turnaround bits and the 16 data bits. It samples MDIO on each rising MDC edge of the data phase. When the frame ends, status bits 15:0 hold the captured word MSB first and bits 31:16 read 0.
- R6: Indication bit 2 (not-valid) is 1 from the cycle after a read launch until the captured data is in the status register. It clears in the same cycle as busy. It is never 1 while busy is 0.
- R7: Configuration bits 2:0 select the MDC period in system clocks from 0 to 7 as 4, 6, 8, 10, 14, 20, 28 and 56. The high and low halves of each period are equal.
- R8: MDC is low whenever no frame is running. MDIO output changes only while MDC is low, at a falling MDC edge.
- R9: While busy, a write to index 3 or a read launch is ignored: no second frame, and index 3 keeps its earlier value.
- R10: A configuration write with bit 31 set aborts any frame. On the next cycle busy, not-valid and MDC are 0 and status is cleared. Bits 2:0 load from the same write, and bit 31 reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO line value from the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable, high to drive |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a soft reset and a read frame in flight. The bench launches a read at the slowest divider, then writes the reset bit a few hundred cycles into the preamble. On the next cycle it judges that busy, not-valid, MDC and status are all cleared together. It then runs a fresh frame to show the engine restarts cleanly.

The second pair is a new launch and a frame already running. The bench writes the data register again in the cycle right after a write launch. It judges at the ports that the register still holds the first value. The scoreboard must also see exactly one frame on the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_HDR,
        S_TA,
        S_DAT
    } mdio_state_e;

    localparam int FIELD_W  = 5;
    localparam int WORD_W   = 16;
    localparam int PRE_BITS = 32;
    localparam int HDR_BITS = 14;
    localparam int TA_BITS  = 2;

    localparam logic [2:0] REG_CFG  = 3'd0;
    localparam logic [2:0] REG_CMD  = 3'd1;
    localparam logic [2:0] REG_ADR  = 3'd2;
    localparam logic [2:0] REG_DAT  = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;
    localparam logic [2:0] REG_IND  = 3'd5;

    // system clocks per MDC half period for each divider select
    function automatic logic [5:0] half_period(input logic [2:0] sel);
        logic [5:0] h;
        case (sel)
            3'd0:    h = 6'd2;
            3'd1:    h = 6'd3;
            3'd2:    h = 6'd4;
            3'd3:    h = 6'd5;
            3'd4:    h = 6'd7;
            3'd5:    h = 6'd10;
            3'd6:    h = 6'd14;
            default: h = 6'd28;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       mdc,
    output logic       rise_p,
    output logic       fall_p
);
    import mdio_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic             wrap;

    assign half_m1 = CNT_W'(half_period(sel) - 6'd1);
    assign wrap    = run && !clr && (cnt == half_m1);
    assign rise_p  = wrap && !mdc;
    assign fall_p  = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (clr || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R8: the clock parks low once the engine stops
    p_mdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        start,
    input  logic        is_rd,
    input  logic [4:0]  phy,
    input  logic [4:0]  regn,
    input  logic [15:0] wdata,
    input  logic        rise_p,
    input  logic        fall_p,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_done,
    output logic [15:0] rd_data
);
    import mdio_pkg::*;

    mdio_state_e state;
    logic [4:0]  bit_cnt;
    logic [31:0] tx_sr;
    logic        rd_op;
    logic [15:0] rx_sr;
    logic        last_fall;

    assign last_fall = (state == S_DAT) && fall_p && (bit_cnt == 5'(WORD_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rd_op   <= 1'b0;
            rx_sr   <= '0;
        end else if (clr) begin
            state   <= S_IDLE;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state   <= S_PRE;
                        bit_cnt <= '0;
                        rd_op   <= is_rd;
                        tx_sr   <= {2'b01, (is_rd ? 2'b10 : 2'b01), phy, regn,
                                    (is_rd ? 2'b11 : 2'b10),
                                    (is_rd ? 16'hFFFF : wdata)};
                    end
                end
                S_PRE: begin
                    if (fall_p) begin
                        if (bit_cnt == 5'(PRE_BITS - 1)) begin
                            state   <= S_HDR;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                S_HDR: begin
                    if (fall_p) begin
                        tx_sr <= {tx_sr[30:0], 1'b1};
                        if (bit_cnt == 5'(HDR_BITS - 1)) begin
                            state   <= S_TA;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                S_TA: begin
                    if (fall_p) begin
                        tx_sr <= {tx_sr[30:0], 1'b1};
                        if (bit_cnt == 5'(TA_BITS - 1)) begin
                            state   <= S_DAT;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                S_DAT: begin
                    if (rise_p && rd_op) begin
                        rx_sr <= {rx_sr[14:0], mdio_i};
                    end
                    if (fall_p) begin
                        tx_sr <= {tx_sr[30:0], 1'b1};
                        if (last_fall) begin
                            state   <= S_IDLE;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b1;
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_PRE:  mdio_oe = 1'b1;
            S_HDR: begin
                mdio_o  = tx_sr[31];
                mdio_oe = 1'b1;
            end
            S_TA, S_DAT: begin
                mdio_o  = tx_sr[31];
                mdio_oe = !rd_op;
            end
        endcase
    end

    assign rd_done = last_fall && rd_op && !clr;
    assign rd_data = rx_sr;

    // R3: a launch taken while idle always enters the preamble
    p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !clr) |=> (state == S_PRE && mdio_oe));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
    parameter int REG_AW = 3,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    import mdio_pkg::*;

    logic [2:0]  cfg_sel;
    logic        cmd_rd;
    logic [4:0]  phy_q;
    logic [4:0]  regn_q;
    logic [15:0] dat_q;
    logic [15:0] stat_q;
    logic        nv_q;

    logic wr_cfg, wr_cmd, wr_adr, wr_dat;
    logic soft_rst, start_wr, start_rd;
    logic busy, rise_p, fall_p, rd_done;
    logic [15:0] rd_data;
    logic unused_bits;

    assign wr_cfg = reg_wr && (reg_addr == REG_AW'(REG_CFG));
    assign wr_cmd = reg_wr && (reg_addr == REG_AW'(REG_CMD));
    assign wr_adr = reg_wr && (reg_addr == REG_AW'(REG_ADR));
    assign wr_dat = reg_wr && (reg_addr == REG_AW'(REG_DAT));

    assign soft_rst = wr_cfg && reg_wdata[31];
    assign start_wr = wr_dat && !busy;
    assign start_rd = wr_cmd && reg_wdata[0] && !cmd_rd && !busy;
    assign unused_bits = &{1'b0, reg_wdata[30:16]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_sel <= 3'd7;
            cmd_rd  <= 1'b0;
            phy_q   <= '0;
            regn_q  <= '0;
            dat_q   <= '0;
            stat_q  <= '0;
            nv_q    <= 1'b0;
        end else begin
            if (wr_cfg) cfg_sel <= reg_wdata[2:0];
            if (wr_cmd) cmd_rd  <= reg_wdata[0];
            if (wr_adr) begin
                phy_q  <= reg_wdata[12:8];
                regn_q <= reg_wdata[4:0];
            end
            if (start_wr) dat_q <= reg_wdata[15:0];
            if (soft_rst) begin
                nv_q   <= 1'b0;
                stat_q <= '0;
            end else if (start_rd) begin
                nv_q <= 1'b1;
            end else if (rd_done) begin
                nv_q   <= 1'b0;
                stat_q <= rd_data;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_AW'(REG_CFG):  reg_rdata = {29'd0, cfg_sel};
            REG_AW'(REG_CMD):  reg_rdata = {31'd0, cmd_rd};
            REG_AW'(REG_ADR):  reg_rdata = {19'd0, phy_q, 3'd0, regn_q};
            REG_AW'(REG_DAT):  reg_rdata = {16'd0, dat_q};
            REG_AW'(REG_STAT): reg_rdata = {16'd0, stat_q};
            REG_AW'(REG_IND):  reg_rdata = {29'd0, nv_q, 1'b0, busy};
            default:           reg_rdata = '0;
        endcase
    end

    mdio_clkgen #(.CNT_W(CNT_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst),
        .run    (busy),
        .sel    (cfg_sel),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_frame_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (soft_rst),
        .start   (start_wr || start_rd),
        .is_rd   (start_rd),
        .phy     (phy_q),
        .regn    (regn_q),
        .wdata   (reg_wdata[15:0]),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_done (rd_done),
        .rd_data (rd_data)
    );

    // R9: a data write that arrives while busy leaves the register untouched
    p_dat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_dat) |=> $stable(dat_q));

    // R6: not-valid never outlives busy
    p_nv_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_q |-> busy);

    // R10: abort clears the engine, flag and clock on the next cycle
    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !nv_q && !mdc && stat_q == 16'd0));

endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] data;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    function automatic logic [15:0] resp(input logic [4:0] p, input logic [4:0] r);
        return {3'b101, p, 3'b010, r};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- monitor / responder ----------------
    logic [63:0] fr_bits = '0;
    logic [63:0] fr_oe = '0;
    int          mon_cnt = 0;
    int          frames_seen = 0;
    logic [4:0]  cur_phy = '0, cur_rg = '0;
    time         rise_t = 0, rise_prev = 0, fall_t = 0;
    int          mdo_bad = 0;

    always @(posedge mdc) begin
        item_t it;
        logic [63:0] eb, eo;
        rise_prev = rise_t;
        rise_t    = $time;
        fr_bits = {fr_bits[62:0], (mdio_oe ? mdio_o : mdio_i)};
        fr_oe   = {fr_oe[62:0], mdio_oe};
        mon_cnt++;
        if (mon_cnt == 46) begin
            cur_phy = fr_bits[9:5];
            cur_rg  = fr_bits[4:0];
        end
        if (mon_cnt == 64) begin
            mon_cnt = 0;
            frames_seen++;
            if (exp_q.size() == 0) begin
                chk("R9", "unexpected frame", 64'd1, 64'd0);
            end else begin
                it = exp_q.pop_front();
                eb = {32'hFFFF_FFFF, 2'b01, (it.rd ? 2'b10 : 2'b01), it.phy, it.rg,
                      2'b1 ^ {1'b0, it.rd} , (it.rd ? resp(it.phy, it.rg) : it.data)};
                eb[17:16] = it.rd ? 2'b11 : 2'b10;
                eo = it.rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
                chk(it.rd ? "R5" : "R3", "frame bits", fr_bits, eb);
                chk(it.rd ? "R5" : "R3", "output enable", fr_oe, eo);
            end
        end
    end

    always @(negedge mdc) begin
        fall_t = $time;
        if (mon_cnt >= 48 && mon_cnt <= 63)
            mdio_i = resp(cur_phy, cur_rg)[63 - mon_cnt];
        else
            mdio_i = 1'b1;
    end

    always @(mdio_o) if (rst_n && mdc) mdo_bad++;

    // ---------------- driver ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd5, v);
            if (v[0] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic push(input logic r, input logic [4:0] p, input logic [4:0] g,
                        input logic [15:0] d);
        item_t it;
        it.rd = r; it.phy = p; it.rg = g; it.data = d;
        exp_q.push_back(it);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); chk("R1", "cfg reset", v, 32'd7);
        rd(3'd1, v); chk("R1", "cmd reset", v, 32'd0);
        rd(3'd2, v); chk("R1", "addr reset", v, 32'd0);
        rd(3'd3, v); chk("R1", "data reset", v, 32'd0);
        rd(3'd4, v); chk("R1", "status reset", v, 32'd0);
        rd(3'd5, v); chk("R1", "ind reset", v, 32'd0);
        chk("R1", "mdc/oe reset", {mdc, mdio_oe}, 2'b00);

        // R2 address masking
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2", "addr mask", v, 32'h0000_1F1F);

        // R3 write frame, fastest divider; R9 second write ignored
        wr(3'd0, 32'd0);
        wr(3'd2, {19'd0, 5'h11, 3'd0, 5'h0A});
        push(1'b0, 5'h11, 5'h0A, 16'hBEEF);
        wr(3'd3, 32'h0000_BEEF);
        rd(3'd5, v); chk("R3", "busy after launch", v, 32'd1);
        wr(3'd3, 32'h0000_1234);
        rd(3'd3, v); chk("R9", "data held while busy", v, 32'h0000_BEEF);
        wait_idle();
        repeat (40) @(negedge clk);
        chk("R9", "queue drained, one frame", exp_q.size(), 0);
        chk("R9", "frame count", frames_seen, 1);
        chk("R8", "mdc low when idle", mdc, 1'b0);

        // R5/R6 read frame
        wr(3'd2, {19'd0, 5'h03, 3'd0, 5'h1F});
        push(1'b1, 5'h03, 5'h1F, 16'd0);
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        rd(3'd5, v); chk("R6", "busy and not-valid", v, 32'd5);
        wait_idle();
        rd(3'd5, v); chk("R6", "flags clear together", v, 32'd0);
        rd(3'd4, v); chk("R5", "status data", v, {16'd0, resp(5'h03, 5'h1F)});

        // R4 level write does not launch
        wr(3'd1, 32'd1);
        rd(3'd5, v); chk("R4", "no launch on level", v, 32'd0);
        repeat (20) @(negedge clk);
        chk("R4", "no extra frame", frames_seen, 2);

        // R7 divider select 3 -> 10 clocks, read path again
        wr(3'd0, 32'd3);
        wr(3'd2, {19'd0, 5'h1F, 3'd0, 5'h00});
        push(1'b1, 5'h1F, 5'h00, 16'd0);
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        wait_idle();
        chk("R7", "period sel3", (rise_t - rise_prev) / CLK_PERIOD, 10);
        chk("R7", "high half sel3", (fall_t - rise_t) / CLK_PERIOD, 5);
        rd(3'd4, v); chk("R5", "status data 2", v, {16'd0, resp(5'h1F, 5'h00)});

        // R7 divider select 7 -> 56 clocks
        wr(3'd0, 32'd7);
        push(1'b0, 5'h1F, 5'h00, 16'h0001);
        wr(3'd3, 32'h0000_0001);
        wait_idle();
        chk("R7", "period sel7", (rise_t - rise_prev) / CLK_PERIOD, 56);
        chk("R7", "high half sel7", (fall_t - rise_t) / CLK_PERIOD, 28);

        // R10 abort a read mid-frame
        wr(3'd1, 32'd0);
        wr(3'd1, 32'd1);
        repeat (300) @(negedge clk);
        wr(3'd0, 32'h8000_0002);
        rd(3'd5, v); chk("R10", "flags after abort", v, 32'd0);
        chk("R10", "mdc after abort", mdc, 1'b0);
        rd(3'd0, v); chk("R10", "cfg readback", v, 32'd2);
        rd(3'd4, v); chk("R10", "status cleared", v, 32'd0);
        mon_cnt = 0;
        mdio_i  = 1'b1;

        // recovery after abort, divider 8
        push(1'b0, 5'h1F, 5'h00, 16'hA5C3);
        wr(3'd3, 32'h0000_A5C3);
        wait_idle();
        repeat (20) @(negedge clk);
        chk("R10", "frame after abort", exp_q.size(), 0);
        chk("R8", "mdio changes only with mdc low", mdo_bad, 0);

        finish_run();
    end

endmodule